// File: doc/BRIEF.md
# Display DMA Descriptor Fetch Engine

This block prepares each channel of a multi-channel display DMA for the next frame. Every frame start launches one pass over all channels. An enabled channel picks where its next descriptor lives and reads that descriptor from memory. A descriptor is four 32-bit words. The block keeps the four words per channel and reports problems to the interrupt logic as single-cycle events.

The descriptor address normally comes from the pointer that the previous descriptor left behind, so descriptors form a linked list. Software can override that list with a one-shot branch request. The request names a new descriptor address, can ask for an event when it is taken, and drops its request flag once it has been used.

Two memory windows limit where descriptors and frame data may live. A descriptor that does not lie wholly inside one window is never read. A channel that ends its fetch with no usable frame source raises a bus-error event tagged with its channel number. A registered readback port shows the stored words of any one channel and the fields decoded from its command word.

Top module: `fdf_fetch_engine`

## Requirements
- R1: After reset, every channel reads back zero in its branch, descriptor pointer, source, frame ID and command registers. No memory read is requested, and no event or done pulse is raised.
- R2: A branch-register write keeps only the bits under mask 0xFFFFFFF3. A descriptor-pointer write keeps only the bits under mask 0xFFFFFFF0. The register is chosen with `cfg_is_desc` (1 = descriptor pointer, 0 = branch).
- R3: If branch bit 0 is set when an enabled channel is served, its descriptor is read from branch bits [31:4] with four zero low bits, and the descriptor pointer is ignored. Bit 0 is then cleared and the other bits are kept. If bit 1 is also set, one `branch_evt` pulse is raised, carrying the channel number.
- R4: If branch bit 0 is clear, the descriptor is read from the descriptor pointer (bits [3:0] forced to zero). The next frame follows the pointer that was loaded from the descriptor's first word.
- R5: A descriptor is read as four word reads, at the base address and then at base+4, base+8 and base+12. Each read holds its address until `mem_rd_ready` completes it. The words are stored in this order: next pointer, source address, frame ID, command.
- R6: A descriptor is read only if all 16 bytes of it lie inside one of the two windows, edges included. Otherwise no read is issued and the stored pointer, ID and command keep their values.
- R7: At every frame start the source register of every channel is cleared. A channel whose enable is low when it is reached issues no read and raises no event.
- R8: An enabled channel whose source is zero after its turn, or whose source word does not lie inside a window, raises one `bus_err_evt` pulse carrying its channel number.
- R9: Channels are served one at a time in ascending index order, with at most one read outstanding. `fetch_done` pulses for one cycle after the last channel.
- R10: The readback port decodes the selected channel's command word as follows: length is bits [20:2] as a byte count, end-of-frame request is bit 21, start-of-frame request is bit 22, and palette-data flag is bit 26.
- R11: A frame start that arrives while a pass is running is ignored. It adds no reads and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_is_desc | input | 1 | 1 selects the descriptor pointer, 0 selects the branch register |
| cfg_ch | input | CHW | Channel being written |
| cfg_wdata | input | 32 | Write data |
| frame_start | input | 1 | Starts a fetch pass (ignored while busy) |
| ch_enable | input | NUM_CH | Per-channel enables |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_ready | input | 1 | Read completes, with data, in this cycle |
| mem_rd_data | input | 32 | Read data |
| branch_evt | output | 1 | Branch-status event pulse |
| branch_ch | output | CHW | Channel of the branch event |
| bus_err_evt | output | 1 | Bus-error event pulse |
| bus_err_ch | output | CHW | Channel of the bus error |
| fetch_done | output | 1 | One-cycle pulse at the end of a pass |
| rd_ch | input | CHW | Channel selected for readback |
| rd_desc | output | 32 | Descriptor pointer of the selected channel |
| rd_src | output | 32 | Source address |
| rd_id | output | 32 | Frame ID |
| rd_cmd | output | 32 | Command word |
| rd_branch | output | 32 | Branch register |
| rd_len | output | 21 | Decoded transfer length in bytes |
| rd_eof_req | output | 1 | Decoded end-of-frame request |
| rd_sof_req | output | 1 | Decoded start-of-frame request |
| rd_pal | output | 1 | Decoded palette-data flag |

## Verification
The properties check the memory port on every cycle. A stalled request must hold its address, every address must be word aligned and inside a window, and the done pulse must be a single cycle with no request beside it. The properties also check that event channel numbers are in range. Only the bench scenarios can show which descriptor was chosen: branch versus chained pointer, the clearing of the one-shot flag, and which words landed in which register. The scenarios also cover bus-error decisions for zero, out-of-window and edge-of-window addresses, the ascending channel order across a sparse enable mask, and a frame start that arrives mid-pass being dropped.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);

  localparam logic [WORD_W-1:0] BR_KEEP   = 32'hFFFF_FFF3;
  localparam logic [WORD_W-1:0] DESC_KEEP = 32'hFFFF_FFF0;
  localparam int BR_REQ_BIT = 0;
  localparam int BR_EVT_BIT = 1;

  localparam int CMD_LEN_LO = 2;
  localparam int CMD_LEN_HI = 20;
  localparam int CMD_EOF    = 21;
  localparam int CMD_SOF    = 22;
  localparam int CMD_PAL    = 26;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_FETCH,
    ST_CHECK,
    ST_NEXT
  } fsm_t;

  typedef enum logic [1:0] {
    W_NEXT = 2'd0,
    W_SRC  = 2'd1,
    W_ID   = 2'd2,
    W_CMD  = 2'd3
  } word_t;
endpackage

// File: rtl/fdf_win_check.sv
module fdf_win_check #(
  parameter int          SPAN    = 16,
  parameter logic [31:0] W0_BASE = 32'h1000_0000,
  parameter logic [31:0] W0_SIZE = 32'h0100_0000,
  parameter logic [31:0] W1_BASE = 32'h2000_0000,
  parameter logic [31:0] W1_SIZE = 32'h0001_0000
) (
  input  logic [31:0] addr,
  output logic        ok
);
  localparam logic [32:0] W0_LO = {1'b0, W0_BASE};
  localparam logic [32:0] W1_LO = {1'b0, W1_BASE};
  localparam logic [32:0] W0_HI = W0_LO + {1'b0, W0_SIZE};
  localparam logic [32:0] W1_HI = W1_LO + {1'b0, W1_SIZE};

  logic [32:0] a_lo, a_hi;
  logic        in0, in1;

  assign a_lo = {1'b0, addr};
  assign a_hi = a_lo + 33'(SPAN);
  assign in0  = (a_lo >= W0_LO) && (a_hi <= W0_HI);
  assign in1  = (a_lo >= W1_LO) && (a_hi <= W1_HI);
  assign ok   = in0 || in1;
endmodule

// File: rtl/fdf_chan_regs.sv
module fdf_chan_regs
  import fdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              br_we,
  input  logic              desc_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              frame_clr,
  input  logic              br_clr,
  input  logic              ld_en,
  input  word_t             ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] branch_q,
  output logic [WORD_W-1:0] desc_q,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] id_q,
  output logic [WORD_W-1:0] cmd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      branch_q <= '0;
      desc_q   <= '0;
      src_q    <= '0;
      id_q     <= '0;
      cmd_q    <= '0;
    end else begin
      // software write wins over the engine's one-shot clear
      if (br_we)       branch_q             <= wdata & BR_KEEP;
      else if (br_clr) branch_q[BR_REQ_BIT] <= 1'b0;

      if (desc_we)                        desc_q <= wdata & DESC_KEEP;
      else if (ld_en && ld_idx == W_NEXT) desc_q <= ld_data;

      if (frame_clr)                     src_q <= '0;
      else if (ld_en && ld_idx == W_SRC) src_q <= ld_data;

      if (ld_en && ld_idx == W_ID)  id_q  <= ld_data;
      if (ld_en && ld_idx == W_CMD) cmd_q <= ld_data;
    end
  end
endmodule

// File: rtl/fdf_cmd_decode.sv
module fdf_cmd_decode
  import fdf_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output logic [CMD_LEN_HI:0] len_bytes,
  output logic              eof_req,
  output logic              sof_req,
  output logic              pal
);
  assign len_bytes = {cmd[CMD_LEN_HI:CMD_LEN_LO], {CMD_LEN_LO{1'b0}}};
  assign eof_req   = cmd[CMD_EOF];
  assign sof_req   = cmd[CMD_SOF];
  assign pal       = cmd[CMD_PAL];
endmodule

// File: rtl/fdf_fetch_engine.sv
module fdf_fetch_engine
  import fdf_pkg::*;
#(
  parameter int          NUM_CH  = 7,
  parameter logic [31:0] W0_BASE = 32'h1000_0000,
  parameter logic [31:0] W0_SIZE = 32'h0100_0000,
  parameter logic [31:0] W1_BASE = 32'h2000_0000,
  parameter logic [31:0] W1_SIZE = 32'h0001_0000,
  localparam int         CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_is_desc,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [31:0]       cfg_wdata,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_enable,
  output logic              mem_rd_valid,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [31:0]       mem_rd_data,
  output logic              branch_evt,
  output logic [CHW-1:0]    branch_ch,
  output logic              bus_err_evt,
  output logic [CHW-1:0]    bus_err_ch,
  output logic              fetch_done,
  input  logic [CHW-1:0]    rd_ch,
  output logic [31:0]       rd_desc,
  output logic [31:0]       rd_src,
  output logic [31:0]       rd_id,
  output logic [31:0]       rd_cmd,
  output logic [31:0]       rd_branch,
  output logic [20:0]       rd_len,
  output logic              rd_eof_req,
  output logic              rd_sof_req,
  output logic              rd_pal
);
  localparam logic [CHW-1:0] LAST_CH   = CHW'(NUM_CH - 1);
  localparam int             WORD_B    = WORD_W / 8;
  localparam logic [31:0]    WORD_STEP = 32'(WORD_B);

  logic [WORD_W-1:0] br_a   [NUM_CH];
  logic [WORD_W-1:0] desc_a [NUM_CH];
  logic [WORD_W-1:0] src_a  [NUM_CH];
  logic [WORD_W-1:0] id_a   [NUM_CH];
  logic [WORD_W-1:0] cmd_a  [NUM_CH];

  fsm_t           state_q;
  logic [CHW-1:0] ch_q;
  word_t          widx_q;
  logic           mem_valid_q;
  logic [31:0]    mem_addr_q;

  logic        hs, frame_go;
  logic [31:0] cur_br, cur_desc, cur_src, sel_ptr;
  logic        ptr_ok, src_ok, cur_en;

  assign hs       = mem_valid_q && mem_rd_ready;
  assign frame_go = (state_q == ST_IDLE) && frame_start;
  assign cur_br   = br_a[ch_q];
  assign cur_desc = desc_a[ch_q];
  assign cur_src  = src_a[ch_q];
  assign cur_en   = ch_enable[ch_q];
  assign sel_ptr  = cur_br[BR_REQ_BIT] ? {cur_br[31:4], 4'h0} : {cur_desc[31:4], 4'h0};

  assign mem_rd_valid = mem_valid_q;
  assign mem_rd_addr  = mem_addr_q;

  fdf_win_check #(
    .SPAN(DESC_BYTES), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
    .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
  ) u_desc_win (.addr(sel_ptr), .ok(ptr_ok));

  fdf_win_check #(
    .SPAN(WORD_B), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
    .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
  ) u_src_win (.addr(cur_src), .ok(src_ok));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic here;
    assign here = (ch_q == CHW'(g));
    fdf_chan_regs u_regs (
      .clk      (clk),
      .rst      (rst),
      .br_we    (cfg_we && !cfg_is_desc && cfg_ch == CHW'(g)),
      .desc_we  (cfg_we &&  cfg_is_desc && cfg_ch == CHW'(g)),
      .wdata    (cfg_wdata),
      .frame_clr(frame_go),
      .br_clr   ((state_q == ST_SEL) && here && ch_enable[g] && br_a[g][BR_REQ_BIT]),
      .ld_en    (hs && here),
      .ld_idx   (widx_q),
      .ld_data  (mem_rd_data),
      .branch_q (br_a[g]),
      .desc_q   (desc_a[g]),
      .src_q    (src_a[g]),
      .id_q     (id_a[g]),
      .cmd_q    (cmd_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ch_q        <= '0;
      widx_q      <= W_NEXT;
      mem_valid_q <= 1'b0;
      mem_addr_q  <= '0;
      branch_evt  <= 1'b0;
      branch_ch   <= '0;
      bus_err_evt <= 1'b0;
      bus_err_ch  <= '0;
      fetch_done  <= 1'b0;
    end else begin
      branch_evt  <= 1'b0;
      bus_err_evt <= 1'b0;
      fetch_done  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (frame_start) begin
            ch_q    <= '0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (!cur_en) begin
            state_q <= ST_NEXT;
          end else begin
            if (cur_br[BR_REQ_BIT] && cur_br[BR_EVT_BIT]) begin
              branch_evt <= 1'b1;
              branch_ch  <= ch_q;
            end
            if (ptr_ok) begin
              mem_valid_q <= 1'b1;
              mem_addr_q  <= sel_ptr;
              widx_q      <= W_NEXT;
              state_q     <= ST_FETCH;
            end else begin
              state_q <= ST_CHECK;
            end
          end
        end
        ST_FETCH: begin
          if (hs) begin
            if (widx_q == W_CMD) begin
              mem_valid_q <= 1'b0;
              state_q     <= ST_CHECK;
            end else begin
              widx_q     <= word_t'(widx_q + 2'd1);
              mem_addr_q <= mem_addr_q + WORD_STEP;
            end
          end
        end
        ST_CHECK: begin
          if (cur_src == '0 || !src_ok) begin
            bus_err_evt <= 1'b1;
            bus_err_ch  <= ch_q;
          end
          state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (ch_q == LAST_CH) begin
            fetch_done <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= ST_SEL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rd_ch > LAST_CH) begin
      rd_desc   <= '0;
      rd_src    <= '0;
      rd_id     <= '0;
      rd_cmd    <= '0;
      rd_branch <= '0;
    end else begin
      rd_desc   <= desc_a[rd_ch];
      rd_src    <= src_a[rd_ch];
      rd_id     <= id_a[rd_ch];
      rd_cmd    <= cmd_a[rd_ch];
      rd_branch <= br_a[rd_ch];
    end
  end

  fdf_cmd_decode u_dec (
    .cmd      (rd_cmd),
    .len_bytes(rd_len),
    .eof_req  (rd_eof_req),
    .sof_req  (rd_sof_req),
    .pal      (rd_pal)
  );
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
  parameter int          NUM_CH  = 7,
  parameter logic [31:0] W0_BASE = 32'h1000_0000,
  parameter logic [31:0] W0_SIZE = 32'h0100_0000,
  parameter logic [31:0] W1_BASE = 32'h2000_0000,
  parameter logic [31:0] W1_SIZE = 32'h0001_0000,
  localparam int         CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_rd_valid,
  input logic           mem_rd_ready,
  input logic [31:0]    mem_rd_addr,
  input logic           fetch_done,
  input logic           branch_evt,
  input logic [CHW-1:0] branch_ch,
  input logic           bus_err_evt,
  input logic [CHW-1:0] bus_err_ch
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NUM_CH - 1);
  logic [32:0] a_lo, a_hi;
  logic        win_hit;

  assign a_lo    = {1'b0, mem_rd_addr};
  assign a_hi    = a_lo + 33'd4;
  assign win_hit = (a_lo >= {1'b0, W0_BASE} && a_hi <= {1'b0, W0_BASE} + {1'b0, W0_SIZE}) ||
                   (a_lo >= {1'b0, W1_BASE} && a_hi <= {1'b0, W1_BASE} + {1'b0, W1_SIZE});

  p_hold_addr_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_word_align_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

  p_read_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> win_hit);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !fetch_done);

  p_done_no_read_r9: assert property (@(posedge clk) disable iff (rst)
    fetch_done |-> !mem_rd_valid);

  p_ber_ch_range_r8: assert property (@(posedge clk) disable iff (rst)
    bus_err_evt |-> bus_err_ch <= LAST_CH);

  p_br_ch_range_r3: assert property (@(posedge clk) disable iff (rst)
    branch_evt |-> branch_ch <= LAST_CH);
endmodule

bind fdf_fetch_engine fdf_checker #(
  .NUM_CH(NUM_CH), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
  .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
) u_fdf_checker (
  .clk(clk), .rst(rst),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .fetch_done(fetch_done),
  .branch_evt(branch_evt), .branch_ch(branch_ch),
  .bus_err_evt(bus_err_evt), .bus_err_ch(bus_err_ch)
);

// File: tb/test_fdf_fetch_engine.sv
`timescale 1ns/1ps
module test_fdf_fetch_engine;
  localparam int NCH = 7;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           cfg_we = 0, cfg_is_desc = 0;
  logic [CW-1:0]  cfg_ch = 0;
  logic [31:0]    cfg_wdata = 0;
  logic           frame_start = 0;
  logic [NCH-1:0] ch_enable = 0;
  logic           mem_rd_valid, mem_rd_ready = 0;
  logic [31:0]    mem_rd_addr, mem_rd_data;
  logic           branch_evt, bus_err_evt, fetch_done;
  logic [CW-1:0]  branch_ch, bus_err_ch, rd_ch = 0;
  logic [31:0]    rd_desc, rd_src, rd_id, rd_cmd, rd_branch;
  logic [20:0]    rd_len;
  logic           rd_eof_req, rd_sof_req, rd_pal;

  fdf_fetch_engine i_fdf_fetch_engine (.*);

  // memory contents computed from the address
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a[3:2])
      2'd0: return a + 32'h100;
      2'd1: begin
        if (a[11:8] == 4'h9) return 32'h0;
        if (a[11:8] == 4'hA) return 32'h0000_4000;
        return 32'h1080_0000 + {16'h0, a[15:0]};
      end
      2'd2: return a ^ 32'hA5A5_0000;
      default: return {5'b0, a[8], 3'b0, 2'b11, a[20:2], 2'b00};
    endcase
  endfunction
  assign mem_rd_data = mem_word(mem_rd_addr);

  int nchk = 0, nerr = 0;
  int rcnt = 0, nlog = 0, nbs = 0, nber = 0, ndone = 0;
  logic [CW-1:0] last_bs, last_ber;
  logic [31:0] rlog [64];

  always @(negedge clk) begin
    rcnt++;
    mem_rd_ready = (rcnt % 3) != 0;
    if (mem_rd_valid && mem_rd_ready) begin
      if (nlog < 64) rlog[nlog] = mem_rd_addr;
      nlog++;
    end
    if (branch_evt) begin nbs++; last_bs = branch_ch; end
    if (bus_err_evt) begin nber++; last_ber = bus_err_ch; end
    if (fetch_done) ndone++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic is_desc, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_is_desc = is_desc; cfg_ch = CW'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic read_ch(input int ch);
    @(negedge clk);
    rd_ch = CW'(ch);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [NCH-1:0] en, input bit extra_start);
    @(negedge clk);
    nlog = 0; nbs = 0; nber = 0; ndone = 0;
    ch_enable = en;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
    end
    while (ndone == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  logic [31:0] m_desc [NCH], m_src [NCH], m_id [NCH], m_cmd [NCH], m_br [NCH];

  task automatic check_model(input int ch, input string req);
    read_ch(ch);
    chk({req, " desc"},   rd_desc,   m_desc[ch]);
    chk({req, " src"},    rd_src,    m_src[ch]);
    chk({req, " id"},     rd_id,     m_id[ch]);
    chk({req, " cmd"},    rd_cmd,    m_cmd[ch]);
    chk({req, " branch"}, rd_branch, m_br[ch]);
  endtask

  task automatic model_fetch(input int ch, input logic [31:0] p);
    m_desc[ch] = mem_word(p);
    m_src[ch]  = mem_word(p + 32'd4);
    m_id[ch]   = mem_word(p + 32'd8);
    m_cmd[ch]  = mem_word(p + 32'd12);
  endtask

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] br;
    logic [31:0] desc;
    logic        fetch;
    logic [31:0] ptr;
    logic        bs;
    logic        ber;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{3'd0, 32'h0000_0000, 32'h1000_0105, 1'b1, 32'h1000_0100, 1'b0, 1'b0},
    '{3'd3, 32'h1000_020F, 32'h2000_0000, 1'b1, 32'h1000_0200, 1'b1, 1'b0},
    '{3'd6, 32'h0000_0000, 32'h1000_0900, 1'b1, 32'h1000_0900, 1'b0, 1'b1},
    '{3'd2, 32'h0000_0000, 32'h1000_0A00, 1'b1, 32'h1000_0A00, 1'b0, 1'b1},
    '{3'd1, 32'h0000_0000, 32'h0800_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b1},
    '{3'd5, 32'h0000_0000, 32'h2000_FFF0, 1'b1, 32'h2000_FFF0, 1'b0, 1'b0},
    '{3'd4, 32'h0000_0000, 32'h2001_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b1},
    '{3'd0, 32'h0FFF_FFF1, 32'h1000_0200, 1'b0, 32'h0000_0000, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_desc[c] = 0; m_src[c] = 0; m_id[c] = 0; m_cmd[c] = 0; m_br[c] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state
    for (int c = 0; c < NCH; c++) check_model(c, "R1 reset");
    chk("R1 mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
    chk("R1 fetch_done",   {31'b0, fetch_done},   32'h0);
    chk("R1 events",       {30'b0, branch_evt, bus_err_evt}, 32'h0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      int c;
      c = int'(VT[v].ch);
      cfg(c, 1'b0, VT[v].br);
      cfg(c, 1'b1, VT[v].desc);
      m_br[c]   = VT[v].br & 32'hFFFF_FFF3;
      m_desc[c] = VT[v].desc & 32'hFFFF_FFF0;
      read_ch(c);
      chk("R2 branch mask", rd_branch, m_br[c]);
      chk("R2 desc mask",   rd_desc,   m_desc[c]);

      run_frame(NCH'(1 << c), 1'b0);
      for (int k = 0; k < NCH; k++) m_src[k] = 0;   // R7 all sources cleared
      if (VT[v].fetch) model_fetch(c, VT[v].ptr);
      if (VT[v].br[0]) m_br[c][0] = 1'b0;           // R3 one-shot clears

      chk("R5/R6 read count", nlog, VT[v].fetch ? 32'd4 : 32'd0);
      if (VT[v].fetch)
        for (int k = 0; k < 4; k++)
          chk("R5 read address order", rlog[k], VT[v].ptr + 32'(4 * k));
      chk("R3 branch events", nbs, {31'b0, VT[v].bs});
      if (VT[v].bs) chk("R3 branch channel", {29'b0, last_bs}, 32'(c));
      chk("R8 bus error events", nber, {31'b0, VT[v].ber});
      if (VT[v].ber) chk("R8 bus error channel", {29'b0, last_ber}, 32'(c));
      chk("R9 done pulses", ndone, 32'd1);
      check_model(c, "R4/R5 stored words");
      chk("R10 decode", {8'b0, rd_pal, rd_sof_req, rd_eof_req, rd_len},
          {8'b0, m_cmd[c][26], m_cmd[c][22], m_cmd[c][21], m_cmd[c][20:2], 2'b00});
    end

    // R4: chaining over two frames on channel 0 (pointer 0x1000_0200 from last vector)
    run_frame(7'b0000001, 1'b0);
    chk("R4 chained fetch base", rlog[0], 32'h1000_0200);
    model_fetch(0, 32'h1000_0200);
    run_frame(7'b0000001, 1'b0);
    chk("R4 follows loaded pointer", rlog[0], 32'h1000_0300);
    model_fetch(0, 32'h1000_0300);
    for (int k = 0; k < NCH; k++) if (k != 0) m_src[k] = 0;
    check_model(0, "R4 chained words");

    // R9/R7/R11: sparse enables, ascending order, mid-pass frame start dropped
    for (int k = 0; k < NCH; k++) begin
      cfg(k, 1'b0, 32'h0);
      cfg(k, 1'b1, 32'h1000_1000 + 32'(k * 32));
      m_br[k] = 0;
      m_desc[k] = 32'h1000_1000 + 32'(k * 32);
    end
    run_frame(7'b1010101, 1'b1);
    chk("R9/R11 read count", nlog, 32'd16);
    for (int j = 0; j < 4; j++)
      for (int w = 0; w < 4; w++)
        chk("R9 ascending order", rlog[j * 4 + w], 32'h1000_1000 + 32'(j * 64 + w * 4));
    chk("R11 single done", ndone, 32'd1);
    chk("R8 no bus error", nber, 32'd0);
    for (int k = 0; k < NCH; k++) begin
      m_src[k] = 0;
      if (k % 2 == 0) model_fetch(k, 32'h1000_1000 + 32'(k * 32));
    end
    check_model(1, "R7 disabled ch1");
    check_model(3, "R7 disabled ch3");
    check_model(4, "R9 ch4 words");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule